// File: doc/BRIEF.md
# DRAM Periodic Refresh Sequencer

This block schedules all-bank refresh for one DRAM rank. A free-running interval timer marks each point at which a refresh becomes due. The sequencer then raises a request towards the command arbiter. While the request waits, it blocks new row activations, so in-flight bursts can finish but no new row is opened. Once the arbiter grants, the sequencer commands a precharge of all banks, waits the row-precharge time, and issues the refresh. It then reports the rank as busy for the refresh cycle time.

A high-temperature input halves the refresh interval. The timer never stops, including during the busy phase, so the refresh points stay on a fixed grid however long the arbiter takes to grant. One refresh covers a group of rows in every bank at once. Per-bank refresh, self-refresh and power-down are not handled here.

Top module: `refresh_ctrl`

## Requirements
- R1: While reset is held and right after it, `ref_req_o`, `pre_all_o`, `refresh_o`, `busy_o` and `act_block_o` are all 0.
- R2: With `hot_i` low, `ref_req_o` first rises exactly INTERVAL clock cycles after reset release. Successive rises are INTERVAL cycles apart.
- R3: With `hot_i` high, successive rises of `ref_req_o` are INTERVAL/2 cycles apart.
- R4: While `ref_req_o` is high and `grant_i` is low, the request stays high, `act_block_o` is high, and neither `pre_all_o` nor `refresh_o` is issued.
- R5: `pre_all_o` is a single-cycle pulse. It occurs in the cycle after a cycle in which both `ref_req_o` and `grant_i` are high, and `ref_req_o` is low in that pulse cycle.
- R6: `refresh_o` is a single-cycle pulse issued exactly RP cycles after the `pre_all_o` pulse.
- R7: `busy_o` is high for exactly RFC consecutive cycles, starting in the `refresh_o` cycle.
- R8: `act_block_o` is high from the first cycle of `ref_req_o` through the last cycle of `busy_o`, and low in every other cycle.
- R9: The delay between request and grant does not move later refreshes. The spacing of request rises stays INTERVAL.
- R10: `grant_i` has no effect while no request is pending. No `pre_all_o`, `refresh_o` or `busy_o` follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | High temperature: halve refresh interval |
| grant_i | input | 1 | Arbiter grant for a pending refresh |
| ref_req_o | output | 1 | Refresh due, waiting for grant |
| act_block_o | output | 1 | Forbid new row activations |
| pre_all_o | output | 1 | Precharge-all command pulse |
| refresh_o | output | 1 | Refresh command pulse |
| busy_o | output | 1 | Rank occupied by refresh |

## Verification
The bench holds the grant back for several cycles and then measures the next request. A timer that paused while waiting, or restarted after the busy phase, would show a spacing longer than INTERVAL. It counts cycles from precharge-all to refresh and the length of the busy window, which catches off-by-one loads of the delay counter. It pulses the grant while idle; a sequencer that did not gate the grant with its own request would issue a stray precharge-all. It also switches the temperature input and measures the halved spacing, which exposes a limit that was not swapped.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PENDING = 3'd1,
    ST_PRE_ALL = 3'd2,
    ST_REFRESH = 3'd3,
    ST_BUSY    = 3'd4
  } ref_state_t;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL = 6240,
  localparam int HALF  = INTERVAL / 2,
  localparam int CNT_W = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic accept_i,
  output logic due_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic             due_q, due_d, tick;

  always_comb begin
    lim_m1 = hot_i ? CNT_W'(HALF - 1) : CNT_W'(INTERVAL - 1);
    tick   = (cnt_q >= lim_m1);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    due_o  = tick | due_q;
    due_d  = due_o & ~accept_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end
endmodule

// File: rtl/refresh_delay_counter.sv
module refresh_delay_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
    zero_o = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
  import refresh_pkg::*;
#(
  parameter int RP  = 11,
  parameter int RFC = 240,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         due_i,
  input  logic         grant_i,
  input  logic         dly_zero_i,
  output logic         idle_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         ref_req_o,
  output logic         act_block_o,
  output logic         pre_all_o,
  output logic         refresh_o,
  output logic         busy_o
);
  ref_state_t st_q, st_d;
  logic       pre_q, pre_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    pre_d      = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (due_i) st_d = ST_PENDING;
      ST_PENDING: if (grant_i) begin
                    st_d       = ST_PRE_ALL;
                    pre_d      = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = W'(RP - 1);
                  end
      ST_PRE_ALL: if (dly_zero_i) st_d = ST_REFRESH;
      ST_REFRESH: begin
                    st_d       = ST_BUSY;
                    load_o     = 1'b1;
                    load_val_o = W'(RFC - 2);
                  end
      ST_BUSY:    if (dly_zero_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pre_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pre_q <= pre_d;
    end
  end

  always_comb begin
    idle_o      = (st_q == ST_IDLE);
    ref_req_o   = (st_q == ST_PENDING);
    act_block_o = (st_q != ST_IDLE);
    pre_all_o   = pre_q;
    refresh_o   = (st_q == ST_REFRESH);
    busy_o      = (st_q == ST_REFRESH) || (st_q == ST_BUSY);
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl #(
  parameter int INTERVAL = 6240,
  parameter int RFC      = 240,
  parameter int RP       = 11,
  localparam int DLY_MAX = (RFC > RP) ? RFC : RP,
  localparam int DLY_W   = $clog2(DLY_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic grant_i,
  output logic ref_req_o,
  output logic act_block_o,
  output logic pre_all_o,
  output logic refresh_o,
  output logic busy_o
);
  logic             due, idle, dly_load, dly_zero;
  logic [DLY_W-1:0] dly_val;

  refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .accept_i(idle), .due_o(due)
  );

  refresh_delay_counter #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load_i(dly_load), .load_val_i(dly_val),
    .zero_o(dly_zero)
  );

  refresh_seq_fsm #(.RP(RP), .RFC(RFC), .W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .due_i(due), .grant_i(grant_i),
    .dly_zero_i(dly_zero), .idle_o(idle), .load_o(dly_load),
    .load_val_o(dly_val), .ref_req_o(ref_req_o), .act_block_o(act_block_o),
    .pre_all_o(pre_all_o), .refresh_o(refresh_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk #(
  parameter int RFC = 240,
  parameter int RP  = 11
) (
  input logic clk,
  input logic rst_n,
  input logic grant_i,
  input logic ref_req_o,
  input logic act_block_o,
  input logic pre_all_o,
  input logic refresh_o,
  input logic busy_o
);
  logic [15:0] since_pre, busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= '0;
      busy_run  <= '0;
    end else begin
      if (pre_all_o)                                 since_pre <= 16'd1;
      else if (since_pre != '0 && since_pre < 16'hFFFF) since_pre <= since_pre + 16'd1;
      busy_run <= busy_o ? busy_run + 16'd1 : 16'd0;
    end
  end

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !grant_i) |=> ref_req_o);
  a_r5_pre_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_all_o) |-> $past(ref_req_o && grant_i));
  a_r5_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_o |=> !pre_all_o);
  a_r6_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> (since_pre == 16'(RP)));
  a_r7_busy_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> busy_o);
  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == 16'(RFC)));
  a_r8_block_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o || pre_all_o || busy_o) |-> act_block_o);
  a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_req_o, pre_all_o, refresh_o}));
endmodule

bind refresh_ctrl refresh_ctrl_chk #(.RFC(RFC), .RP(RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .ref_req_o(ref_req_o),
  .act_block_o(act_block_o), .pre_all_o(pre_all_o), .refresh_o(refresh_o),
  .busy_o(busy_o)
);

// File: tb/test_refresh_ctrl.sv
module test_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 64;
  localparam int RFC        = 10;
  localparam int RP         = 3;

  logic clk = 1'b0;
  logic rst_n, hot_i, grant_i;
  logic ref_req_o, act_block_o, pre_all_o, refresh_o, busy_o;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_ctrl #(.INTERVAL(INTERVAL), .RFC(RFC), .RP(RP)) i_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .grant_i(grant_i),
    .ref_req_o(ref_req_o), .act_block_o(act_block_o), .pre_all_o(pre_all_o),
    .refresh_o(refresh_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // serve one refresh, grant held back gd cycles; returns time stamps
  task automatic serve(input int gd, output int t_req, output int t_pre,
                       output int t_ref, output int blen);
    int w = 0;
    while (!ref_req_o && w < 2000) begin step(); w++; end
    chk(ref_req_o, "watchdog request", 0, 1);
    t_req = cyc;
    for (int i = 0; i < gd; i++) begin
      chk(ref_req_o && act_block_o && !pre_all_o && !refresh_o, "R4",
          {ref_req_o, act_block_o, pre_all_o, refresh_o}, 4'b1100);
      step();
    end
    chk(act_block_o, "R8 block during request", act_block_o, 1);
    grant_i = 1'b1;
    step();
    grant_i = 1'b0;
    chk(pre_all_o && !ref_req_o, "R5 precharge-all after grant",
        {pre_all_o, ref_req_o}, 2'b10);
    t_pre = cyc;
    w = 0;
    step();
    chk(!pre_all_o, "R5 single pulse", pre_all_o, 0);
    while (!refresh_o && w < 200) begin
      chk(act_block_o, "R8 block during precharge", act_block_o, 1);
      step(); w++;
    end
    t_ref = cyc;
    blen = 0;
    w = 0;
    while (busy_o && w < 500) begin blen++; step(); w++; end
    chk(!act_block_o, "R8 block released after busy", act_block_o, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hot_i = 1'b0; grant_i = 1'b0;
    repeat (3) step();
    chk({ref_req_o, act_block_o, pre_all_o, refresh_o, busy_o} == 5'b0,
        "R1 in reset", {ref_req_o, act_block_o, pre_all_o, refresh_o, busy_o}, 0);
    rst_n = 1'b1;
    step();
    chk({ref_req_o, act_block_o, pre_all_o, refresh_o, busy_o} == 5'b0,
        "R1 after release", {ref_req_o, act_block_o, pre_all_o, refresh_o, busy_o}, 0);
  endtask

  task automatic t_normal_and_drift();
    int t0, tq1, tp1, tr1, b1, tq2, tp2, tr2, b2, tq3, tp3, tr3, b3;
    t0 = cyc - 1;
    serve(0, tq1, tp1, tr1, b1);
    chk(tq1 - t0 == INTERVAL, "R2 first request", tq1 - t0, INTERVAL);
    chk(tp1 - tq1 == 1, "R5 grant to precharge", tp1 - tq1, 1);
    chk(tr1 - tp1 == RP, "R6 precharge to refresh", tr1 - tp1, RP);
    chk(b1 == RFC, "R7 busy length", b1, RFC);
    serve(7, tq2, tp2, tr2, b2);
    chk(tq2 - tq1 == INTERVAL, "R2 period", tq2 - tq1, INTERVAL);
    chk(tp2 - tq2 == 8, "R4 wait for delayed grant", tp2 - tq2, 8);
    chk(tr2 - tp2 == RP, "R6 after delayed grant", tr2 - tp2, RP);
    chk(b2 == RFC, "R7 busy length delayed", b2, RFC);
    serve(0, tq3, tp3, tr3, b3);
    chk(tq3 - tq2 == INTERVAL, "R9 no drift after delayed grant", tq3 - tq2, INTERVAL);
  endtask

  task automatic t_idle_grant();
    int seen = 0;
    grant_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      if (pre_all_o || refresh_o || busy_o) seen++;
    end
    grant_i = 1'b0;
    step();
    chk(seen == 0 && !act_block_o, "R10 idle grant ignored", seen, 0);
  endtask

  task automatic t_hot();
    int a, b, c, d, q1, q2;
    hot_i = 1'b1;
    serve(0, a, b, c, d);
    serve(0, q1, b, c, d);
    serve(2, q2, b, c, d);
    chk(q2 - q1 == INTERVAL/2, "R3 halved interval", q2 - q1, INTERVAL/2);
    chk(d == RFC, "R7 busy length hot", d, RFC);
    hot_i = 1'b0;
    serve(0, a, b, c, d);
    serve(0, q1, b, c, d);
    serve(0, q2, b, c, d);
    chk(q2 - q1 == INTERVAL, "R2 interval restored", q2 - q1, INTERVAL);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hot_i = 1'b0; grant_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal_and_drift();
    t_idle_grant();
    t_hot();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule